// File: doc/BRIEF.md
# Processor Signature Patch Matcher

This block decides whether a patch image is meant for the processor it sits in. It holds the processor's 32-bit signature and derives a one-hot platform flag from a 3-bit platform identifier. That identifier is taken from the high word of a 64-bit platform register. The image is then streamed in, one 32-bit word per accepted beat. The block first compares the signature and platform mask held in the fixed header. If that comparison fails and the header sizes show an extended signature table, it walks the table entry by entry. It stops at the first entry that matches, or after the last entry. It then raises `done` and reports the verdict on `hit`.

A `start` pulse opens a new image. Only the fixed header and the extended table are streamed; the data section between them is skipped by whoever feeds the block. Checksums are not checked here. After `done`, the verdict is held and further beats have no effect until the next `start`.

Top module: `sig_patch_matcher`

## Requirements
- R1: A signature candidate can match only when its 32-bit signature word equals `cpu_sig` in every bit.
- R2: A candidate whose platform mask word is zero matches any platform. A nonzero mask matches only when mask AND `plat_flag` is nonzero.
- R3: `plat_flag` is an 8-bit one-hot value equal to 1 shifted left by `plat_reg_hi[20:18]`.
- R4: While `virt_present` is high, the platform identifier is taken as 0, so `plat_flag` equals 8'h01.
- R5: The extended table is walked only when the effective total size is greater than the effective data size plus the 48-byte header. Otherwise a primary miss ends with `done` high and `hit` low, one cycle after header word 11 is accepted.
- R6: When the data-size word is zero, the block uses a data size of 2000 and a total size of 2048 in place of the header fields. Such an image therefore never has an extended table, whatever its total-size word says.
- R7: Stream order is fixed. First come 12 header words, with the signature at index 3, the mask at 6, the data size at 7 and the total size at 8. Then come the table words: count, checksum and three spare words. Last come `count` entries of three words each: signature, mask, checksum.
- R8: The header candidate is checked first. If it matches, `done` and `hit` rise one cycle after header word 11 is accepted, and no table word is consumed.
- R9: The first matching table entry ends the walk. `done` and `hit` rise one cycle after that entry's mask word is accepted.
- R10: If no entry matches, `done` rises with `hit` low one cycle after the last entry's checksum word. With a count of zero, this happens one cycle after the fifth table word.
- R11: `done` and `hit` hold their values, and beats are ignored, from `done` until the next `start`. Beats before the first `start` after reset are also ignored.
- R12: `start` clears `done` and `hit` on the next edge and restarts the walk at header word 0, even in the middle of an image. A beat in the same cycle as `start` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sig | input | 32 | Processor signature |
| plat_reg_hi | input | 32 | High word of the platform register |
| virt_present | input | 1 | Forces the platform identifier to zero |
| start | input | 1 | Begins a new image |
| beat_valid | input | 1 | A stream word is present |
| beat_data | input | 32 | Stream word |
| plat_flag | output | 8 | One-hot platform flag |
| done | output | 1 | Verdict available, held until `start` |
| hit | output | 1 | Image applies, valid while `done` |

## Verification
Suppose the word position or the remaining-entry count is off by one. The verdict then moves by at least one beat: `done` rises a cycle early or late, or it lands on the wrong entry's mask. A per-cycle model comparison exposes this on the exact edge where it happens. A wrong size decision shows up the cycle after header word 11, as `done` failing to rise, or rising when it should not. A flag or mask fault turns a match into a miss at the same point. Stale state left over after `start` appears as a verdict on the next image that differs from the model's.

// File: rtl/sig_match_pkg.sv
// Shared types and stream word positions for the signature patch matcher.
package sig_match_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_XHDR,
        ST_ENT,
        ST_DONE
    } walk_state_e;

    // Header word positions decoded by the walker
    localparam int unsigned HDR_SIG_IDX   = 3;
    localparam int unsigned HDR_MASK_IDX  = 6;
    localparam int unsigned HDR_DSIZE_IDX = 7;
    localparam int unsigned HDR_TSIZE_IDX = 8;
    // Table prologue and entry lengths in words
    localparam int unsigned XHDR_WORDS    = 5;
    localparam int unsigned ENT_WORDS     = 3;
endpackage

// File: rtl/plat_flag_gen.sv
// Derives the one-hot platform flag from a field of the platform register word.
// Assumes ID_LSB + ID_W <= PREG_W. Purely combinational; clk/rst_n only guard checks.
module plat_flag_gen #(
    parameter int PREG_W = 32,
    parameter int ID_W   = 3,
    parameter int ID_LSB = 18,
    localparam int FLAG_W = 1 << ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PREG_W-1:0] preg_hi,
    input  logic              virt_present,
    output logic [FLAG_W-1:0] flag
);
    logic [ID_W-1:0] plat_id;

    // Select the identifier field, forced to zero under virtualisation
    always_comb begin
        plat_id = virt_present ? '0 : preg_hi[ID_LSB +: ID_W];
    end

    // Decode one flag bit per possible identifier value
    for (genvar i = 0; i < FLAG_W; i++) begin : g_dec
        assign flag[i] = (plat_id == ID_W'(i));
    end

    // R3: the flag always carries exactly one set bit
    p_flag_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flag) == 1);
    // R4: virtualisation pins the flag to bit 0
    p_virt_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        virt_present |-> flag == FLAG_W'(1));
endmodule

// File: rtl/sig_entry_cmp.sv
// Compares one signature candidate against the processor signature and flag.
// Assumes FLAG_W <= W; the mask bits above the flag width cannot match.
module sig_entry_cmp #(
    parameter int W      = 32,
    parameter int FLAG_W = 8
) (
    input  logic [W-1:0]      cpu_sig,
    input  logic [FLAG_W-1:0] cpu_flag,
    input  logic [W-1:0]      cand_sig,
    input  logic [W-1:0]      cand_mask,
    output logic              is_hit
);
    logic sig_eq;
    logic mask_ok;

    // Exact signature equality and mask acceptance (zero mask accepts all)
    always_comb begin
        sig_eq  = (cand_sig == cpu_sig);
        mask_ok = (cand_mask == '0) || (|(cand_mask[FLAG_W-1:0] & cpu_flag));
        is_hit  = sig_eq && mask_ok;
    end
endmodule

// File: rtl/ext_presence.sv
// Decides from the header size words whether an extended table follows.
// A zero data-size word selects the default data and total sizes.
module ext_presence #(
    parameter int W              = 32,
    parameter int HDR_BYTES      = 48,
    parameter int DEF_DATA_BYTES = 2000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dsize_word,
    input  logic [W-1:0] tsize_word,
    output logic         has_ext
);
    localparam int SW = W + 2;
    localparam logic [SW-1:0] DEF_DATA  = SW'(DEF_DATA_BYTES);
    localparam logic [SW-1:0] DEF_TOTAL = SW'(DEF_DATA_BYTES + HDR_BYTES);

    logic [SW-1:0] eff_data;
    logic [SW-1:0] eff_total;

    // Resolve effective sizes and compare without overflow
    always_comb begin
        eff_data  = (dsize_word == '0) ? DEF_DATA  : SW'(dsize_word);
        eff_total = (dsize_word == '0) ? DEF_TOTAL : SW'(tsize_word);
        has_ext   = eff_total > (eff_data + SW'(HDR_BYTES));
    end

    // R6: a default-sized image never reports a table
    p_default_noext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dsize_word == '0) |-> !has_ext);
endmodule

// File: rtl/sig_patch_matcher.sv
// Streams an image header and optional extended signature table and reports
// whether the image applies to this processor. Assumes the feeder omits the
// data section and sends table words right after the header.
module sig_patch_matcher #(
    parameter int W              = 32,
    parameter int HDR_BYTES      = 48,
    parameter int DEF_DATA_BYTES = 2000,
    parameter int CNT_W          = 32,
    parameter int ID_W           = 3,
    parameter int ID_LSB         = 18,
    localparam int FLAG_W        = 1 << ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      cpu_sig,
    input  logic [W-1:0]      plat_reg_hi,
    input  logic              virt_present,
    input  logic              start,
    input  logic              beat_valid,
    input  logic [W-1:0]      beat_data,
    output logic [FLAG_W-1:0] plat_flag,
    output logic              done,
    output logic              hit
);
    import sig_match_pkg::*;

    localparam int HDR_WORDS = HDR_BYTES / 4;
    localparam int POS_W     = $clog2(HDR_WORDS + 1);
    localparam logic [POS_W-1:0] P_HDR_LAST = POS_W'(HDR_WORDS - 1);
    localparam logic [POS_W-1:0] P_SIG      = POS_W'(HDR_SIG_IDX);
    localparam logic [POS_W-1:0] P_MASK     = POS_W'(HDR_MASK_IDX);
    localparam logic [POS_W-1:0] P_DSIZE    = POS_W'(HDR_DSIZE_IDX);
    localparam logic [POS_W-1:0] P_TSIZE    = POS_W'(HDR_TSIZE_IDX);
    localparam logic [POS_W-1:0] P_XLAST    = POS_W'(XHDR_WORDS - 1);
    localparam logic [POS_W-1:0] P_ELAST    = POS_W'(ENT_WORDS - 1);

    walk_state_e      state;
    logic [POS_W-1:0] pos;
    logic [CNT_W-1:0] left;
    logic [W-1:0]     hdr_sig, hdr_mask, hdr_dsize, hdr_tsize, ent_sig;
    logic             done_q, hit_q;
    logic             take;
    logic             has_ext;
    logic [W-1:0]     cand_sig, cand_mask;
    logic             cand_hit;

    plat_flag_gen #(.PREG_W(W), .ID_W(ID_W), .ID_LSB(ID_LSB)) u_flag (
        .clk(clk), .rst_n(rst_n), .preg_hi(plat_reg_hi),
        .virt_present(virt_present), .flag(plat_flag)
    );

    ext_presence #(.W(W), .HDR_BYTES(HDR_BYTES), .DEF_DATA_BYTES(DEF_DATA_BYTES)) u_ext (
        .clk(clk), .rst_n(rst_n), .dsize_word(hdr_dsize),
        .tsize_word(hdr_tsize), .has_ext(has_ext)
    );

    // One comparator shared by the header candidate and the table entries
    always_comb begin
        cand_sig  = (state == ST_ENT) ? ent_sig   : hdr_sig;
        cand_mask = (state == ST_ENT) ? beat_data : hdr_mask;
    end

    sig_entry_cmp #(.W(W), .FLAG_W(FLAG_W)) u_cmp (
        .cpu_sig(cpu_sig), .cpu_flag(plat_flag), .cand_sig(cand_sig),
        .cand_mask(cand_mask), .is_hit(cand_hit)
    );

    // A beat counts only while a walk is in progress and no start is pending
    always_comb begin
        take = beat_valid && !start &&
               (state == ST_HDR || state == ST_XHDR || state == ST_ENT);
    end

    // Walk sequencer: header capture, table prologue, entry scan, verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pos       <= '0;
            left      <= '0;
            hdr_sig   <= '0;
            hdr_mask  <= '0;
            hdr_dsize <= '0;
            hdr_tsize <= '0;
            ent_sig   <= '0;
            done_q    <= 1'b0;
            hit_q     <= 1'b0;
        end else if (start) begin
            state  <= ST_HDR;
            pos    <= '0;
            done_q <= 1'b0;
            hit_q  <= 1'b0;
        end else if (take) begin
            case (state)
                ST_HDR: begin
                    if (pos == P_SIG)   hdr_sig   <= beat_data;
                    if (pos == P_MASK)  hdr_mask  <= beat_data;
                    if (pos == P_DSIZE) hdr_dsize <= beat_data;
                    if (pos == P_TSIZE) hdr_tsize <= beat_data;
                    if (pos == P_HDR_LAST) begin
                        pos <= '0;
                        if (cand_hit) begin
                            state <= ST_DONE; done_q <= 1'b1; hit_q <= 1'b1;
                        end else if (has_ext) begin
                            state <= ST_XHDR;
                        end else begin
                            state <= ST_DONE; done_q <= 1'b1;
                        end
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                ST_XHDR: begin
                    if (pos == '0) left <= CNT_W'(beat_data);
                    if (pos == P_XLAST) begin
                        pos <= '0;
                        if (left == '0) begin
                            state <= ST_DONE; done_q <= 1'b1;
                        end else begin
                            state <= ST_ENT;
                        end
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                ST_ENT: begin
                    if (pos == '0) begin
                        ent_sig <= beat_data;
                        pos     <= pos + 1'b1;
                    end else if (pos == POS_W'(1)) begin
                        if (cand_hit) begin
                            state <= ST_DONE; done_q <= 1'b1; hit_q <= 1'b1;
                        end
                        pos <= pos + 1'b1;
                    end else if (pos == P_ELAST) begin
                        pos <= '0;
                        if (left == CNT_W'(1)) begin
                            state <= ST_DONE; done_q <= 1'b1;
                        end else begin
                            left <= left - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign done = done_q;
    assign hit  = hit_q;

    // R8: a positive verdict is only ever shown together with done
    p_hit_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> done);
    // R11: the verdict is held until the next start
    p_verdict_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(hit)));
    // R12: start always clears the verdict on the next edge
    p_start_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && !hit));
    // R10: the walk never sits in the table with no entries left to scan
    p_left_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENT) |-> (left != '0));
endmodule

// File: tb/sig_patch_matcher_test.sv
module sig_patch_matcher_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_sig = 32'h000806C1;
    logic [31:0] plat_reg_hi = 32'h0;
    logic        virt_present = 1'b0;
    logic        start = 1'b0;
    logic        beat_valid = 1'b0;
    logic [31:0] beat_data = 32'h0;
    logic [7:0]  plat_flag;
    logic        done, hit;

    int total = 0;
    int bad = 0;
    string cur_req = "R11";
    bit cmp_en = 1'b0;

    sig_patch_matcher uut (
        .clk(clk), .rst_n(rst_n), .cpu_sig(cpu_sig), .plat_reg_hi(plat_reg_hi),
        .virt_present(virt_present), .start(start), .beat_valid(beat_valid),
        .beat_data(beat_data), .plat_flag(plat_flag), .done(done), .hit(hit)
    );

    always #10 clk = ~clk;

    // Reference model state
    int unsigned mq[$];
    bit m_active = 0, m_done = 0, m_hit = 0;
    int unsigned img[$];

    function automatic logic [7:0] exp_flag();
        return virt_present ? 8'h01 : (8'h01 << plat_reg_hi[20:18]);
    endfunction

    function automatic bit cand_ok(int unsigned s, int unsigned m);
        return (s == cpu_sig) && (m == 0 || (m & {24'h0, exp_flag()}) != 0);
    endfunction

    // 0 pending, 1 hit, 2 miss, judged on the words received so far
    function automatic int judge();
        int unsigned ds, ts, et, ed, cnt;
        int j;
        if (mq.size() < 12) return 0;
        if (mq.size() == 12) begin
            if (cand_ok(mq[3], mq[6])) return 1;
            ds = mq[7]; ts = mq[8];
            et = (ds == 0) ? 2048 : ts;
            ed = (ds == 0) ? 2000 : ds;
            if (longint'(et) > longint'(ed) + 48) return 0;
            return 2;
        end
        if (mq.size() < 13) return 0;
        cnt = mq[12];
        j = 0;
        while (j < int'(cnt)) begin
            if (mq.size() <= 17 + 3*j + 1) return 0;
            if (cand_ok(mq[17 + 3*j], mq[18 + 3*j])) return 1;
            if (mq.size() <= 17 + 3*j + 2) return 0;
            j++;
        end
        return (mq.size() >= 17) ? 2 : 0;
    endfunction

    // Model advance at each clock edge
    always @(posedge clk) begin
        int r;
        if (!rst_n) begin
            mq.delete(); m_active = 0; m_done = 0; m_hit = 0;
        end else if (start) begin
            mq.delete(); m_active = 1; m_done = 0; m_hit = 0;
        end else if (m_active && !m_done && beat_valid) begin
            mq.push_back(beat_data);
            r = judge();
            if (r != 0) begin m_done = 1; m_hit = (r == 1); end
        end
    end

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #5;
        if (rst_n && cmp_en) begin
            chk(done == m_done, cur_req, "done", {31'h0, done}, {31'h0, m_done});
            chk(hit == m_hit, cur_req, "hit", {31'h0, hit}, {31'h0, m_hit});
            chk(plat_flag == exp_flag(), "R3", "plat_flag", {24'h0, plat_flag}, {24'h0, exp_flag()});
        end
    end

    task automatic mk_hdr(int unsigned s, int unsigned m, int unsigned ds, int unsigned ts);
        img.delete();
        img = '{32'h1, 32'h2F, 32'h20240101, s, 32'hABCD, 32'h1, m, ds, ts, 0, 0, 0};
    endtask
    task automatic add_xhdr(int unsigned cnt);
        img.push_back(cnt); img.push_back(32'h55); img.push_back(0);
        img.push_back(0); img.push_back(0);
    endtask
    task automatic add_ent(int unsigned s, int unsigned m);
        img.push_back(s); img.push_back(m); img.push_back(32'h77);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask
    task automatic send_img();
        foreach (img[i]) begin
            beat_valid = 1'b1; beat_data = img[i];
            @(negedge clk);
        end
        beat_valid = 1'b0;
    endtask
    task automatic run(bit exp_hit, string tag);
        cur_req = tag;
        pulse_start();
        send_img();
        @(negedge clk); @(negedge clk);
        chk(done === 1'b1, tag, "final done", {31'h0, done}, 32'h1);
        chk(hit === exp_hit, tag, "final hit", {31'h0, hit}, {31'h0, exp_hit});
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        plat_reg_hi = 32'h5 << 18;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0 && hit === 1'b0, "R12", "reset verdict", {30'h0, done, hit}, 32'h0);
        cmp_en = 1'b1;

        // R3: flag decode for two identifiers
        chk(plat_flag === 8'h20, "R3", "flag id5", {24'h0, plat_flag}, 32'h20);
        plat_reg_hi = (32'h2 << 18) | 32'hFFE3FFFF; @(negedge clk);
        chk(plat_flag === 8'h04, "R3", "flag id2", {24'h0, plat_flag}, 32'h04);
        // R4: virtualisation forces identifier zero
        virt_present = 1'b1; @(negedge clk);
        chk(plat_flag === 8'h01, "R4", "virt flag", {24'h0, plat_flag}, 32'h01);
        virt_present = 1'b0;
        plat_reg_hi = 32'h5 << 18;

        // R11: beats before any start are ignored
        cur_req = "R11";
        mk_hdr(cpu_sig, 32'h20, 0, 0); send_img();
        @(negedge clk);
        chk(done === 1'b0, "R11", "no verdict before start", {31'h0, done}, 32'h0);

        // R1/R8: exact primary match with mask covering the flag
        mk_hdr(cpu_sig, 32'h21, 0, 0); run(1'b1, "R1");
        // R1: one-bit signature difference misses (default size, no table)
        mk_hdr(cpu_sig ^ 32'h100, 32'h21, 0, 0); run(1'b0, "R1");
        // R2: zero mask accepts; disjoint mask rejects
        mk_hdr(cpu_sig, 32'h0, 0, 0); run(1'b1, "R2");
        mk_hdr(cpu_sig, 32'h1F, 0, 0); run(1'b0, "R2");
        // R6: zero data size ignores a large total; trailing table words ignored (R11)
        mk_hdr(32'h1, 32'h0, 0, 32'h10000); add_xhdr(1); add_ent(cpu_sig, 0); run(1'b0, "R6");
        chk(hit === 1'b0, "R11", "trailing beats ignored", {31'h0, hit}, 32'h0);
        // R5: total equal to data plus header means no table
        mk_hdr(32'h1, 32'h0, 1024, 1072); add_xhdr(1); add_ent(cpu_sig, 0); run(1'b0, "R5");
        // R9/R7: second of three entries matches
        mk_hdr(32'h1, 32'h0, 1024, 1072 + 20 + 36);
        add_xhdr(3); add_ent(32'h9, 0); add_ent(cpu_sig, 32'h20); add_ent(cpu_sig, 0);
        run(1'b1, "R9");
        // R7: table entry whose mask misses the flag, then the last one hits
        mk_hdr(32'h1, 32'h0, 1024, 1072 + 20 + 24);
        add_xhdr(2); add_ent(cpu_sig, 32'h40); add_ent(cpu_sig, 32'h20);
        run(1'b1, "R7");
        // R10: no entry matches
        mk_hdr(32'h1, 32'h0, 1024, 1072 + 20 + 24);
        add_xhdr(2); add_ent(32'h9, 0); add_ent(cpu_sig, 32'h2); run(1'b0, "R10");
        // R10: empty table
        mk_hdr(32'h1, 32'h0, 1024, 1072 + 20); add_xhdr(0); run(1'b0, "R10");
        // R8: primary hit wins even when a table exists
        mk_hdr(cpu_sig, 32'h20, 1024, 1072 + 20 + 12);
        add_xhdr(1); add_ent(32'h3, 0); run(1'b1, "R8");
        // R12: restart in the middle of an image
        cur_req = "R12";
        pulse_start();
        mk_hdr(cpu_sig, 32'h0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            beat_valid = 1'b1; beat_data = img[k]; @(negedge clk);
        end
        beat_valid = 1'b0;
        mk_hdr(cpu_sig, 32'h1, 0, 0);
        run(1'b0, "R12");

        cmp_en = 1'b0;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule